// File: doc/BRIEF.md
# Spread-Spectrum Excitation Pattern Generator

This block makes the digital drive pattern for a spread-spectrum excitation source. A 12-stage linear feedback shift register steps through a maximal-length pseudo-random chip sequence of 4095 chips. Each chip is bi-phase coded: the chip value is XORed with the chip clock, so the chip value appears unchanged in the first half of the chip and inverted in the second half. The coded stream has no constant runs longer than two half-chips, which moves its energy away from DC.

The chip clock comes from a programmable divider on the system clock. With the default divider and a 100 MHz system clock, the whole sequence repeats at about 10 Hz. That is above the 1.5 Hz measurement bandwidth downstream, so the repetition adds no low-frequency content. A one-cycle strobe marks the start of every chip. A one-cycle sync pulse marks each return of the register to its seed, which is the start of a new period. An enable input freezes the whole pattern while it is low.

Top module: `pn_excite_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `chip_stb` and `period_sync` are 0, the register holds `SEED`, `pn_bit` equals `SEED[11]` and `enc_bit` equals `pn_bit`.
- R2: With `en` held high, every half-chip lasts exactly `HALF_DIV` clock cycles and every chip lasts two half-chips (`2*HALF_DIV` cycles).
- R3: `enc_bit` equals `pn_bit` during the first half of each chip and equals `~pn_bit` during the second half.
- R4: The chip values follow b[k] = b[k-12] ^ b[k-6] ^ b[k-4] ^ b[k-1] (polynomial x^12+x^6+x^4+x+1). The first twelve chips after reset are the `SEED` bits, most significant bit first.
- R5: The register never holds all zeros, and the sequence repeats every 4095 chips.
- R6: Each full period contains 2048 chips of value 1 and 2047 chips of value 0.
- R7: `chip_stb` is high for exactly one cycle, the first cycle of each new chip. It is never high in two consecutive cycles.
- R8: `period_sync` is high for one cycle, together with `chip_stb`, in the first cycle of each chip in which the register is back at `SEED`. This happens first 4095 chips after reset and then every 4095 chips.
- R9: No run of equal `enc_bit` levels lasts longer than two half-chips (`2*HALF_DIV` enabled cycles).
- R10: While `en` is low, the divider, the chip phase and the register hold. In the following cycle `pn_bit` and `enc_bit` are unchanged and `chip_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low freezes the pattern |
| enc_bit | output | 1 | Bi-phase coded drive bit |
| pn_bit | output | 1 | Raw pseudo-random chip value |
| chip_stb | output | 1 | One-cycle pulse at the start of each chip |
| period_sync | output | 1 | One-cycle pulse at the start of each sequence period |

## Verification
The assertions check these on every cycle: the register never reaches zero, strobes never last two cycles, the coded bit matches the chip value when a chip starts, sync only comes with a strobe and the seed state, a low enable freezes the outputs, and a run-length counter keeps the coded level within two half-chips. The bench scenarios cover what no single-cycle property can show: the exact chip recurrence against a behavioural sequence model, the 4095-chip period measured between two syncs, the 2048/2047 balance over a full period, the exact half-chip timing, and correct restart after a reset in the middle of a run.

// File: rtl/pn_gen_pkg.sv
// Package: shared defaults for the excitation pattern generator.
// Assumes a 12-stage register; the tap mask marks x^12, x^6, x^4 and x^1
// as state bits 11, 5, 3 and 0 of a left-shifting Fibonacci register.
package pn_gen_pkg;
    localparam int              PN_W_DEF     = 12;
    localparam logic [11:0]     PN_TAPS_DEF  = 12'h829;
    localparam logic [11:0]     PN_SEED_DEF  = 12'hACE;
    // 100 MHz / (2 * 4095 chips * 10 Hz) is about 1221 cycles per half-chip.
    localparam int              HALF_DIV_DEF = 1221;
endpackage

// File: rtl/pn_halfchip_div.sv
// Module: pn_halfchip_div
// Divides the system clock down to a one-cycle half-chip tick.
// Assumes HALF_DIV >= 1. The counter holds while en is low.
module pn_halfchip_div #(
    parameter int HALF_DIV = 1221
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic half_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          at_last;

    // Terminal count of the current half-chip.
    assign at_last   = (cnt_q == CW'(HALF_DIV - 1));
    assign half_tick = en && at_last;

    // Half-chip cycle counter, wraps at HALF_DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/pn_lfsr.sv
// Module: pn_lfsr
// Fibonacci shift register: shifts left, feeds the XOR of the tapped bits
// into bit 0. Assumes TAPS describes a primitive polynomial and SEED is
// nonzero. wrap flags an advance that lands back on SEED.
module pn_lfsr #(
    parameter int           W    = 12,
    parameter logic [W-1:0] TAPS = 12'h829,
    parameter logic [W-1:0] SEED = 12'hACE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state,
    output logic         wrap
);
    logic [W-1:0] state_q;
    logic [W-1:0] tap_terms;
    logic [W-1:0] state_nxt;

    // One AND term per stage; untapped stages contribute zero.
    for (genvar i = 0; i < W; i++) begin : g_tap
        assign tap_terms[i] = TAPS[i] & state_q[i];
    end

    assign state_nxt = {state_q[W-2:0], ^tap_terms};
    assign state     = state_q;
    assign wrap      = adv && (state_nxt == SEED);

    // Register update: load seed on reset, step on each chip end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (adv)
            state_q <= state_nxt;
    end
endmodule

// File: rtl/pn_biphase.sv
// Module: pn_biphase
// Tracks which half of the chip is active and codes the chip value with it.
// Phase 0 is the first half. Assumes half_tick is a one-cycle pulse.
module pn_biphase (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic pn_in,
    output logic chip_end,
    output logic enc_out
);
    logic phase_q;

    // A chip ends on the tick that closes its second half.
    assign chip_end = half_tick && phase_q;
    // Chip clock XOR chip value.
    assign enc_out  = pn_in ^ phase_q;

    // Half-chip phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (half_tick)
            phase_q <= ~phase_q;
    end
endmodule

// File: rtl/pn_excite_gen.sv
// Module: pn_excite_gen (top)
// Bi-phase coded maximal-length excitation pattern. The divider gives
// half-chip ticks, the phase tracker codes the chip value, and the shift
// register steps once per chip. The strobe and sync outputs are registered.
// Assumes HALF_DIV >= 1 and a nonzero SEED.
module pn_excite_gen
    import pn_gen_pkg::*;
#(
    parameter int           W        = PN_W_DEF,
    parameter logic [W-1:0] TAPS     = PN_TAPS_DEF,
    parameter logic [W-1:0] SEED     = PN_SEED_DEF,
    parameter int           HALF_DIV = HALF_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic enc_bit,
    output logic pn_bit,
    output logic chip_stb,
    output logic period_sync
);
    logic         half_tick;
    logic         chip_end;
    logic         wrap;
    logic [W-1:0] lfsr_state;
    logic         stb_q;
    logic         sync_q;

    pn_halfchip_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .half_tick (half_tick)
    );

    pn_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (chip_end),
        .state (lfsr_state),
        .wrap  (wrap)
    );

    pn_biphase u_bph (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .pn_in     (lfsr_state[W-1]),
        .chip_end  (chip_end),
        .enc_out   (enc_bit)
    );

    // Strobes aligned with the first cycle of the new chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            stb_q  <= chip_end;
            sync_q <= wrap;
        end
    end

    assign pn_bit      = lfsr_state[W-1];
    assign chip_stb    = stb_q;
    assign period_sync = sync_q;
endmodule

// File: rtl/pn_excite_chk.sv
// Module: pn_excite_chk
// Property checker bound to pn_excite_gen. Watches the ports and the
// register state. Holds a run-length counter for the coded output.
module pn_excite_chk #(
    parameter int           W        = 12,
    parameter logic [W-1:0] SEED     = 12'hACE,
    parameter int           HALF_DIV = 1221
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         enc_bit,
    input logic         pn_bit,
    input logic         chip_stb,
    input logic         period_sync,
    input logic [W-1:0] state
);
    logic rst_d;
    logic enc_d;
    logic en_d;
    int   run_q;
    int   run_now;

    // Previous-cycle copy of reset, used to spot the first active cycle.
    always_ff @(posedge clk) rst_d <= rst_n;

    // Length of the current coded level, in enabled cycles.
    always_comb begin
        if (enc_bit != enc_d)
            run_now = 1;
        else if (en_d)
            run_now = run_q + 1;
        else
            run_now = run_q;
    end

    // Run-length bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_d <= enc_bit;
            en_d  <= 1'b0;
            run_q <= 1;
        end else begin
            enc_d <= enc_bit;
            en_d  <= en;
            run_q <= run_now;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        (rst_d == 1'b0 && rst_n) |-> (!chip_stb && !period_sync && state == SEED))
        else $error("R1 state after reset");

    assert_first_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chip_stb |-> (enc_bit == pn_bit))
        else $error("R3 coded bit at chip start");

    assert_never_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0)
        else $error("R5 register reached zero");

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_stb |=> !chip_stb)
        else $error("R7 strobe longer than one cycle");

    assert_sync_at_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_sync |-> (chip_stb && state == SEED))
        else $error("R8 sync without strobe or seed");

    assert_run_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_now <= 2 * HALF_DIV)
        else $error("R9 coded run too long");

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && rst_d) |=> ($stable(pn_bit) && $stable(enc_bit) && !chip_stb))
        else $error("R10 pattern moved while disabled");
endmodule

bind pn_excite_gen pn_excite_chk #(
    .W        (W),
    .SEED     (SEED),
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .enc_bit     (enc_bit),
    .pn_bit      (pn_bit),
    .chip_stb    (chip_stb),
    .period_sync (period_sync),
    .state       (lfsr_state)
);

// File: tb/pn_excite_gen_tb.sv
// Bench for pn_excite_gen: a behavioural chip-sequence model (bit array
// filled by the recurrence, enabled-edge counter) compared on every clock,
// plus period, balance, run-length, freeze and reset scenarios.
module pn_excite_gen_tb;
    localparam int          D     = 3;
    localparam logic [11:0] SEED  = 12'hACE;
    localparam int          SEQ_N = 12300;
    localparam int          CHIP  = 2 * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic enc_bit, pn_bit, chip_stb, period_sync;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit seq [SEQ_N];
    int m = 0;
    bit last_inc = 1'b0;
    bit started = 1'b0;
    bit cont_en = 1'b0;

    // Statistics gathered during continuous enable
    int  run_len = 0, max_run = 0;
    bit  prev_enc = 1'b0;
    int  since_stb = 0, bad_spacing = 0, spacing_seen = 0;
    int  sync_n = 0, chips = 0, ones = 0;
    bit  have_prev = 1'b0;

    pn_excite_gen #(.SEED(SEED), .HALF_DIV(D)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .enc_bit     (enc_bit),
        .pn_bit      (pn_bit),
        .chip_stb    (chip_stb),
        .period_sync (period_sync)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit seed_at(input int c);
        for (int j = 0; j < 12; j++)
            if (seq[c + j] != SEED[11 - j]) return 1'b0;
        return 1'b1;
    endfunction

    // Model: count enabled edges since reset.
    always @(posedge clk) begin
        cycles++;
        started = 1'b1;
        if (!rst_n) begin
            m = 0; last_inc = 1'b0;
        end else if (en) begin
            m++; last_inc = 1'b1;
        end else begin
            last_inc = 1'b0;
        end
    end

    // Per-cycle comparison and scenario statistics.
    always @(negedge clk) begin
        if (started) begin
            int  h, c;
            bit  ph, pn_e, enc_e, stb_e, sync_e;
            h      = m / D;
            ph     = h[0];
            c      = h / 2;
            pn_e   = seq[c];
            enc_e  = pn_e ^ ph;
            stb_e  = last_inc && (m > 0) && (m % CHIP == 0);
            sync_e = stb_e && seed_at(c);
            check(pn_bit == pn_e,       "R4", "pn_bit",      pn_bit,      pn_e);
            check(enc_bit == enc_e,     "R3", "enc_bit",     enc_bit,     enc_e);
            check(chip_stb == stb_e,    "R7", "chip_stb",    chip_stb,    stb_e);
            check(period_sync == sync_e,"R8", "period_sync", period_sync, sync_e);
        end
        if (cont_en && rst_n) begin
            // R9 run length of the coded level
            if (have_prev && enc_bit == prev_enc) run_len++;
            else run_len = 1;
            if (run_len > max_run) max_run = run_len;
            prev_enc  = enc_bit;
            have_prev = 1'b1;
            // R2 chip spacing
            since_stb++;
            if (chip_stb) begin
                if (spacing_seen > 0 && since_stb != CHIP) bad_spacing++;
                spacing_seen++;
                since_stb = 0;
                if (period_sync) begin
                    sync_n++;
                    if (sync_n == 1)
                        check(chips + 1 == 4095, "R8", "chips to first sync", chips + 1, 4095);
                    else begin
                        check(chips == 4095, "R5", "chips per period", chips, 4095);
                        check(ones == 2048,  "R6", "ones per period",  ones,  2048);
                    end
                    chips = 0; ones = 0;
                end
                chips++;
                if (pn_bit) ones++;
            end
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < SEQ_N; n++)
            seq[n] = (n < 12) ? SEED[11 - n]
                              : (seq[n-12] ^ seq[n-6] ^ seq[n-4] ^ seq[n-1]);

        // R1 reset state
        repeat (4) @(negedge clk);
        check(chip_stb == 1'b0,    "R1", "stb in reset",  chip_stb,    0);
        check(period_sync == 1'b0, "R1", "sync in reset", period_sync, 0);
        check(pn_bit == SEED[11],  "R1", "pn in reset",   pn_bit,      SEED[11]);
        check(enc_bit == pn_bit,   "R1", "enc in reset",  enc_bit,     pn_bit);

        // Continuous run over two full periods (R2, R5, R6, R9)
        rst_n = 1'b1; en = 1'b1; cont_en = 1'b1;
        repeat (2 * 4095 * CHIP + 100 * CHIP) @(negedge clk);
        cont_en = 1'b0;
        check(sync_n >= 2,      "R5", "syncs seen",        sync_n,      2);
        check(bad_spacing == 0, "R2", "bad chip spacings", bad_spacing, 0);
        check(max_run <= CHIP,  "R9", "longest coded run", max_run,     CHIP);
        check(max_run == CHIP,  "R9", "double run reached",max_run,     CHIP);

        // R10: freeze just before a chip boundary
        do @(negedge clk); while (!chip_stb);
        repeat (CHIP - 1) @(negedge clk);
        en = 1'b0;
        begin
            bit snap_pn, snap_enc;
            snap_pn = pn_bit; snap_enc = enc_bit;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                check(pn_bit == snap_pn,   "R10", "pn held",  pn_bit,   snap_pn);
                check(enc_bit == snap_enc, "R10", "enc held", enc_bit,  snap_enc);
                check(chip_stb == 1'b0,    "R10", "no stb",   chip_stb, 0);
            end
        end

        // Irregular enable pattern, model-compared each cycle
        for (int i = 0; i < 3000; i++) begin
            en = ((i * 7) % 5) != 0;
            @(negedge clk);
        end
        en = 1'b1;
        repeat (50) @(negedge clk);

        // Reset in the middle of a run (R1)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(chip_stb == 1'b0,   "R1", "stb in mid reset", chip_stb, 0);
        check(pn_bit == SEED[11], "R1", "pn in mid reset",  pn_bit,   SEED[11]);
        rst_n = 1'b1;
        @(negedge clk);
        check(chip_stb == 1'b0,    "R1", "stb after release",  chip_stb,    0);
        check(period_sync == 1'b0, "R1", "sync after release", period_sync, 0);
        repeat (300) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule